// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm

This block keeps a free-running seconds count for a larger chip. A slow-clock tick enable, one system-clock cycle wide per slow-clock period, drives a 16-bit prescaler. The prescaler emits one step every programmed number of ticks, and each step advances a 20-bit counter. On every step the new count is compared with a programmable alarm value.

The block reports two sticky flags. One records that the counter has advanced. The other records that an alarm match has occurred. A status-read strobe clears both flags. The live count is always visible on an output port, so software can read it back at any time.

Writing a new prescaler setting restarts the prescaler and the count. Interrupt gathering, calendar conversion and battery-backed retention belong to other blocks.

Top module: `rtc_alarm_top`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `count_out` is 0, both flags are 0, and the prescale setting behaves as 0.
- R2: With a prescale setting N in the range 1 to 65535, the counter advances by exactly 1 on the clock edge that takes the N-th tick since the last step or mode write. It does not advance on any earlier tick.
- R3: A prescale setting of 0 means 65536 ticks per step.
- R4: `flag_inc` is set on the same edge on which the counter advances. It then stays set until a status read clears it.
- R5: A cycle with `status_rd` high clears both flags on that edge. The exception is a flag whose event happens on the same edge: that flag stays set.
- R6: `flag_alm` is set only on an edge where the counter advances and the new count equals the alarm value. Writing an alarm value equal to the current count does not set it.
- R7: An alarm value of 0 matches only when the counter wraps to 0, which is 2^CNT_W steps after a restart.
- R8: The counter wraps from its all-ones value to 0.
- R9: A mode write loads the new prescale setting and clears both the prescaler phase and the count to 0 on that edge. It leaves the flags unchanged.
- R10: In cycles with no tick and no mode write, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slck_tick | input | 1 | One-cycle enable for each slow-clock period |
| mode_wr | input | 1 | Write strobe for the prescale setting |
| mode_presc | input | PRESC_W (16) | Prescale setting; 0 means 65536 |
| alarm_wr | input | 1 | Write strobe for the alarm value |
| alarm_val | input | CNT_W (20) | Alarm value |
| status_rd | input | 1 | Status read strobe; clears both flags |
| count_out | output | CNT_W (20) | Current count |
| flag_inc | output | 1 | Sticky flag: the counter has advanced |
| flag_alm | output | 1 | Sticky flag: an alarm match has occurred |

## Verification
Every result registers on the edge that takes its stimulus. The count and both flags change on the edge of the final required tick. A mode write or a status read takes effect on its own edge. The bench drives inputs on falling edges and samples on the very next falling edge, which is exactly one register stage after the stimulus. The bench builds the block with an 8-bit count, so the wrap and the zero-alarm case take 256 steps. It also issues the full 65536 ticks to prove that a prescale setting of 0 means 65536.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Sticky status carried from the status stage to the top.
    typedef struct packed {
        logic alm;
        logic inc;
    } rtc_flags_t;

    // Per-cycle events from the counter stage.
    typedef struct packed {
        logic step;
        logic match;
    } rtc_event_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               reload,
    input  logic [PRESC_W-1:0] presc_in,
    output logic               step
);
    // The register holds (setting - 1), so a setting of 0 wraps to all ones
    // and gives 2^PRESC_W ticks per step.
    localparam logic [PRESC_W-1:0] ONE = PRESC_W'(1);

    logic [PRESC_W-1:0] last_q;
    logic [PRESC_W-1:0] phase_q;

    assign step = tick && !reload && (phase_q == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= '1;
            phase_q <= '0;
        end else if (reload) begin
            last_q  <= presc_in - ONE;
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= (phase_q == last_q) ? '0 : phase_q + ONE;
        end
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        phase_q <= last_q); // R2

    AST_RELOAD_PHASE: assert property (@(posedge clk) disable iff (rst)
        reload |=> (phase_q == '0)); // R9
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             clear,
    input  logic             alarm_wr,
    input  logic [CNT_W-1:0] alarm_in,
    output logic [CNT_W-1:0] count,
    output rtc_event_t       evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] nxt;

    // Natural wrap: all ones plus one gives 0, so an alarm of 0 waits a full lap.
    assign nxt       = count + ONE;
    assign evt.step  = step;
    assign evt.match = step && (nxt == alarm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            alarm_q <= '0;
        end else begin
            if (alarm_wr) alarm_q <= alarm_in;
            if (clear)      count <= '0;
            else if (step)  count <= nxt;
        end
    end

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> (count == $past(count) + ONE)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(count)); // R10

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0)); // R9
endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rtc_event_t evt,
    input  logic       rd,
    output rtc_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            // An event on the read edge wins over the clear.
            flags.inc <= evt.step  | (flags.inc & ~rd);
            flags.alm <= evt.match | (flags.alm & ~rd);
        end
    end

    AST_ALM_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.alm) |-> $past(evt.step)); // R6

    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd && !evt.step) |=> !flags.inc); // R5

    AST_INC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.inc && !rd) |=> flags.inc); // R4
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
    import rtc_pkg::*;
#(
    parameter int PRESC_W = 16,
    parameter int CNT_W   = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slck_tick,
    input  logic               mode_wr,
    input  logic [PRESC_W-1:0] mode_presc,
    input  logic               alarm_wr,
    input  logic [CNT_W-1:0]   alarm_val,
    input  logic               status_rd,
    output logic [CNT_W-1:0]   count_out,
    output logic               flag_inc,
    output logic               flag_alm
);
    logic       step;
    rtc_event_t evt;
    rtc_flags_t flags;

    rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .tick     (slck_tick),
        .reload   (mode_wr),
        .presc_in (mode_presc),
        .step     (step)
    );

    rtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .clear    (mode_wr),
        .alarm_wr (alarm_wr),
        .alarm_in (alarm_val),
        .count    (count_out),
        .evt      (evt)
    );

    rtc_status u_stat (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .rd    (status_rd),
        .flags (flags)
    );

    assign flag_inc = flags.inc;
    assign flag_alm = flags.alm;

    AST_MODE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !status_rd) |=> (flag_inc == $past(flag_inc))); // R9
endmodule

// File: tb/rtc_alarm_top_tb_top.sv
module rtc_alarm_top_tb_top;
    localparam int PW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slck_tick = 1'b0;
    logic          mode_wr = 1'b0;
    logic [PW-1:0] mode_presc = '0;
    logic          alarm_wr = 1'b0;
    logic [CW-1:0] alarm_val = '0;
    logic          status_rd = 1'b0;
    logic [CW-1:0] count_out;
    logic          flag_inc;
    logic          flag_alm;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_top #(.PRESC_W(PW), .CNT_W(CW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .slck_tick  (slck_tick),
        .mode_wr    (mode_wr),
        .mode_presc (mode_presc),
        .alarm_wr   (alarm_wr),
        .alarm_val  (alarm_val),
        .status_rd  (status_rd),
        .count_out  (count_out),
        .flag_inc   (flag_inc),
        .flag_alm   (flag_alm)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            slck_tick = 1'b1;
            @(negedge clk);
        end
        slck_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(input logic [PW-1:0] p);
        mode_presc = p; mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic write_alarm(input logic [CW-1:0] a);
        alarm_val = a; alarm_wr = 1'b1;
        @(negedge clk);
        alarm_wr = 1'b0;
    endtask

    task automatic read_status();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "count after reset", int'(count_out), 0);
        check("R1", "inc after reset", int'(flag_inc), 0);
        check("R1", "alm after reset", int'(flag_alm), 0);
    endtask

    task automatic t_prescale();
        write_mode(16'd5);
        ticks(4);
        check("R2", "count after 4 of 5 ticks", int'(count_out), 0);
        check("R4", "inc before step", int'(flag_inc), 0);
        ticks(1);
        check("R2", "count after 5 ticks", int'(count_out), 1);
        check("R4", "inc on step", int'(flag_inc), 1);
        idle(10);
        check("R10", "count held without ticks", int'(count_out), 1);
        check("R4", "inc sticky", int'(flag_inc), 1);
    endtask

    task automatic t_read();
        read_status();
        check("R5", "inc cleared by read", int'(flag_inc), 0);
        ticks(4);
        slck_tick = 1'b1; status_rd = 1'b1;
        @(negedge clk);
        slck_tick = 1'b0; status_rd = 1'b0;
        check("R5", "inc kept on read with step", int'(flag_inc), 1);
        check("R2", "count after second step", int'(count_out), 2);
    endtask

    task automatic t_alarm();
        read_status();
        write_alarm(8'd2);
        idle(3);
        check("R6", "alarm equal to count without step", int'(flag_alm), 0);
        write_alarm(8'd4);
        ticks(9);
        check("R6", "alarm before match", int'(flag_alm), 0);
        ticks(1);
        check("R6", "count at match", int'(count_out), 4);
        check("R6", "alarm on match", int'(flag_alm), 1);
        read_status();
        check("R5", "alarm cleared by read", int'(flag_alm), 0);
        ticks(5);
        check("R6", "no alarm past match", int'(flag_alm), 0);
    endtask

    task automatic t_mode_clear();
        check("R9", "inc set before mode write", int'(flag_inc), 1);
        ticks(3);
        write_mode(16'd5);
        check("R9", "count cleared by mode write", int'(count_out), 0);
        check("R9", "inc kept by mode write", int'(flag_inc), 1);
        ticks(4);
        check("R9", "phase restarted", int'(count_out), 0);
        ticks(1);
        check("R9", "first step after restart", int'(count_out), 1);
    endtask

    task automatic t_zero_presc();
        write_mode(16'd0);
        ticks(65535);
        check("R3", "count after 65535 ticks", int'(count_out), 0);
        ticks(1);
        check("R3", "count after 65536 ticks", int'(count_out), 1);
    endtask

    task automatic t_wrap();
        write_mode(16'd1);
        write_alarm(8'd0);
        read_status();
        ticks(255);
        check("R8", "count at top", int'(count_out), 255);
        check("R7", "zero alarm before wrap", int'(flag_alm), 0);
        ticks(1);
        check("R8", "count wrapped", int'(count_out), 0);
        check("R7", "zero alarm at wrap", int'(flag_alm), 1);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_read();
        t_alarm();
        t_mode_clear();
        t_zero_presc();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule